// File: doc/BRIEF.md
# Amplifier Driver Guard and Power Sequencer

This block is the digital supervisor that decides, cycle by cycle, whether the output stage of a class-D amplifier may drive its load. It watches the chip-enable input, a power-on-reset hold, and four comparator flags: over-temperature, safe-temperature, output over-current and supply under-voltage. From these it produces a single driver-enable output, level indications for the power-up and power-down ramps, a ramp-complete flag, and three sticky fault records.

Raising the enable input starts a timed power-up ramp. The drivers come on only when the ramp ends. Dropping the enable input starts a shorter power-down ramp. A thermal trip cuts the drivers at once. They stay off until the safe-temperature flag has held without a break for a recovery window. An over-current flag counts as a short only after it has persisted for a filter window. A short holds the drivers off for an off period and then retries, and this repeats for as long as the short stays. Under-voltage gates only the drivers; the sequencing keeps running. Every window is a count of clock cycles set by a parameter, so one clock sets all the timing.

All inputs are expected to be synchronous to `clk`.

Top module: `amp_guard_seq`

## Requirements
- R1: While `rst_n` is low or `por_hold` is high, `drv_en` is 0. One clock edge after `por_hold` is seen high, `pup_busy`, `pdn_busy`, `ramp_done` and all three sticky bits are 0.
- R2: In the idle state, `en` high starts a power-up ramp. `pup_busy` is 1 for UP_CYCLES cycles, then `ramp_done` becomes 1. `drv_en` is never 1 unless `ramp_done` is 1.
- R3: `en` low forces `drv_en` to 0 in the same cycle and starts a power-down ramp. `pdn_busy` is 1 for DOWN_CYCLES cycles, and `en` returning high during that ramp takes effect only after the ramp ends. `en` low also clears any thermal lockout and any short-circuit off period.
- R4: `ot_flag` high forces `drv_en` to 0 in the same cycle. With `en` high it sets `st_therm` at the next clock edge.
- R5: After a thermal trip, `drv_en` returns only once `ot_flag` is low and `safe_flag` has been high for RECOVER_CYCLES consecutive cycles. A single low cycle of `safe_flag` restarts that count.
- R6: An `oc_flag` pulse shorter than FILTER_CYCLES cycles leaves `drv_en` at 1 and leaves `st_short` at 0.
- R7: `oc_flag` held for FILTER_CYCLES cycles while the drivers are on turns `drv_en` off for OFF_CYCLES cycles and sets `st_short`.
- R8: While `oc_flag` stays high, the drivers retry after each off period. They stay on for FILTER_CYCLES cycles and then go off again, and this cycle repeats.
- R9: `uv_flag` high forces `drv_en` to 0 in the same cycle and sets `st_uv`, while `ramp_done` stays 1. `drv_en` returns one cycle after `uv_flag` falls.
- R10: The sticky bits `st_therm`, `st_short` and `st_uv` are 0 one clock edge after `en` is seen low.
- R11: `en` low during a power-up ramp aborts the ramp: the next cycle shows `pdn_busy` 1 and `pup_busy` 0. At most one of `pup_busy`, `pdn_busy` and `ramp_done` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, sets all timing windows |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_hold | input | 1 | Power-on-reset hold, high keeps everything powered down |
| en | input | 1 | Chip enable, high requests operation |
| ot_flag | input | 1 | Over-temperature comparator flag |
| safe_flag | input | 1 | Safe-temperature comparator flag |
| oc_flag | input | 1 | Output over-current comparator flag |
| uv_flag | input | 1 | Supply under-voltage comparator flag |
| drv_en | output | 1 | Output driver enable |
| pup_busy | output | 1 | Power-up ramp in progress |
| pdn_busy | output | 1 | Power-down ramp in progress |
| ramp_done | output | 1 | Sequencing complete, block in live state |
| st_therm | output | 1 | Sticky: thermal trip seen |
| st_short | output | 1 | Sticky: short circuit seen |
| st_uv | output | 1 | Sticky: under-voltage seen |

## Verification
The enable path is driven with a clean rise, a fall that returns high mid-ramp, and an abort during the power-up ramp. Measuring the ramp lengths and checking the order of states tells the idle, ramp, live and fall states apart. The over-current flag is given a pulse one cycle shorter than the filter and then a held level. The pulse separates a glitch from a trip, and the held level shows that the off period and the retry repeat with the right lengths. The thermal path is given a safe window broken by one low cycle, which shows that the recovery count restarts instead of summing. Under-voltage and a fault that is cleared by enable are used to show that only the drivers are gated and that dropping enable wipes the fault state.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RAMP = 2'd1,
      SEQ_LIVE = 2'd2,
      SEQ_FALL = 2'd3
   } seq_state_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/amp_guard_timer.sv
module amp_guard_timer #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic done
);
   localparam int unsigned W = amp_guard_pkg::cnt_width(LIMIT);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] cnt_q;

   // done is high in the LIMIT-th consecutive cycle of run
   assign done = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (run && !done)
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/amp_guard_thermal.sv
module amp_guard_thermal #(
   parameter int unsigned RECOVER_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ot,
   input  logic safe,
   output logic lock
);
   logic cool_run;
   logic cool_done;

   assign cool_run = lock && safe && !ot;

   amp_guard_timer #(.LIMIT(RECOVER_CYCLES)) u_cool (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr || !cool_run),
      .run  (cool_run),
      .done (cool_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock <= 1'b0;
      else if (clr)
         lock <= 1'b0;
      else if (ot)
         lock <= 1'b1;
      else if (cool_done)
         lock <= 1'b0;
   end

endmodule

// File: rtl/amp_guard_short.sv
module amp_guard_short #(
   parameter int unsigned FILTER_CYCLES = 8,
   parameter int unsigned OFF_CYCLES    = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic arm,
   input  logic oc,
   output logic off,
   output logic trip
);
   logic flt_run;
   logic off_done;

   assign flt_run = arm && oc && !off;

   amp_guard_timer #(.LIMIT(FILTER_CYCLES)) u_filter (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr || !flt_run),
      .run  (flt_run),
      .done (trip)
   );

   amp_guard_timer #(.LIMIT(OFF_CYCLES)) u_offwin (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr || !off),
      .run  (off),
      .done (off_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         off <= 1'b0;
      else if (clr)
         off <= 1'b0;
      else if (trip)
         off <= 1'b1;
      else if (off_done)
         off <= 1'b0;
   end

endmodule

// File: rtl/amp_guard_seq.sv
module amp_guard_seq
   import amp_guard_pkg::*;
#(
   parameter int unsigned UP_CYCLES      = 680000,
   parameter int unsigned DOWN_CYCLES    = 6000,
   parameter int unsigned FILTER_CYCLES  = 2800,
   parameter int unsigned OFF_CYCLES     = 9400000,
   parameter int unsigned RECOVER_CYCLES = 9400000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic por_hold,
   input  logic en,
   input  logic ot_flag,
   input  logic safe_flag,
   input  logic oc_flag,
   input  logic uv_flag,
   output logic drv_en,
   output logic pup_busy,
   output logic pdn_busy,
   output logic ramp_done,
   output logic st_therm,
   output logic st_short,
   output logic st_uv
);

   if (UP_CYCLES < 1 || DOWN_CYCLES < 1) begin : g_bad_ramp
      $error("ramp windows must be at least one cycle");
   end
   if (FILTER_CYCLES < 1 || OFF_CYCLES < 1 || RECOVER_CYCLES < 1) begin : g_bad_fault
      $error("fault windows must be at least one cycle");
   end

   seq_state_t st_q, st_d;
   logic up_done, dn_done;
   logic fault_clr;
   logic th_lock;
   logic sc_off, sc_trip;
   logic arm;

   assign fault_clr = por_hold || !en;

   amp_guard_timer #(.LIMIT(UP_CYCLES)) u_up (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (st_q != SEQ_RAMP),
      .run  (st_q == SEQ_RAMP),
      .done (up_done)
   );

   amp_guard_timer #(.LIMIT(DOWN_CYCLES)) u_dn (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (st_q != SEQ_FALL),
      .run  (st_q == SEQ_FALL),
      .done (dn_done)
   );

   amp_guard_thermal #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_therm (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (fault_clr),
      .ot   (ot_flag),
      .safe (safe_flag),
      .lock (th_lock)
   );

   // drivers would be live apart from the short-circuit guard
   assign arm = (st_q == SEQ_LIVE) && en && !por_hold && !ot_flag
                && !th_lock && !uv_flag;

   amp_guard_short #(
      .FILTER_CYCLES(FILTER_CYCLES),
      .OFF_CYCLES   (OFF_CYCLES)
   ) u_short (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (fault_clr),
      .arm  (arm),
      .oc   (oc_flag),
      .off  (sc_off),
      .trip (sc_trip)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SEQ_IDLE: if (en) st_d = SEQ_RAMP;
         SEQ_RAMP: begin
            if (!en)          st_d = SEQ_FALL;
            else if (up_done) st_d = SEQ_LIVE;
         end
         SEQ_LIVE: if (!en) st_d = SEQ_FALL;
         SEQ_FALL: if (dn_done) st_d = SEQ_IDLE;
         default:  st_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= SEQ_IDLE;
      else if (por_hold)
         st_q <= SEQ_IDLE;
      else
         st_q <= st_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_therm <= 1'b0;
         st_short <= 1'b0;
         st_uv    <= 1'b0;
      end else if (fault_clr) begin
         st_therm <= 1'b0;
         st_short <= 1'b0;
         st_uv    <= 1'b0;
      end else begin
         if (ot_flag) st_therm <= 1'b1;
         if (sc_trip) st_short <= 1'b1;
         if (uv_flag) st_uv    <= 1'b1;
      end
   end

   assign pup_busy  = (st_q == SEQ_RAMP);
   assign pdn_busy  = (st_q == SEQ_FALL);
   assign ramp_done = (st_q == SEQ_LIVE);
   assign drv_en    = arm && !sc_off;

endmodule

// File: rtl/amp_guard_seq_chk.sv
module amp_guard_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic por_hold,
   input logic en,
   input logic ot_flag,
   input logic uv_flag,
   input logic drv_en,
   input logic pup_busy,
   input logic pdn_busy,
   input logic ramp_done,
   input logic st_therm,
   input logic st_short,
   input logic st_uv
);

   assert_por_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      por_hold |=> (!pup_busy && !pdn_busy && !ramp_done && !st_therm && !st_short && !st_uv));

   assert_por_nodrive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      por_hold |-> !drv_en);

   assert_drive_after_ramp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> ramp_done);

   assert_en_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !drv_en);

   assert_ot_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ot_flag |-> !drv_en);

   assert_ot_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ot_flag && !por_hold) |=> st_therm);

   assert_short_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_short) |-> !drv_en);

   assert_uv_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flag |-> !drv_en);

   assert_sticky_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!st_therm && !st_short && !st_uv));

   assert_one_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pup_busy, pdn_busy, ramp_done}));

   assert_fall_from_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdn_busy) |-> !$past(en));

endmodule

bind amp_guard_seq amp_guard_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .por_hold (por_hold),
   .en       (en),
   .ot_flag  (ot_flag),
   .uv_flag  (uv_flag),
   .drv_en   (drv_en),
   .pup_busy (pup_busy),
   .pdn_busy (pdn_busy),
   .ramp_done(ramp_done),
   .st_therm (st_therm),
   .st_short (st_short),
   .st_uv    (st_uv)
);

// File: tb/amp_guard_seq_bench.sv
`timescale 1ns/1ps
module amp_guard_seq_bench;

   localparam int UP   = 40;
   localparam int DOWN = 8;
   localparam int FILT = 6;
   localparam int OFFW = 30;
   localparam int REC  = 25;

   logic clk = 1'b0;
   logic rst_n, por_hold, en, ot_flag, safe_flag, oc_flag, uv_flag;
   logic drv_en, pup_busy, pdn_busy, ramp_done, st_therm, st_short, st_uv;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   amp_guard_seq #(
      .UP_CYCLES(UP), .DOWN_CYCLES(DOWN), .FILTER_CYCLES(FILT),
      .OFF_CYCLES(OFFW), .RECOVER_CYCLES(REC)
   ) u_amp_guard_seq (
      .clk(clk), .rst_n(rst_n), .por_hold(por_hold), .en(en),
      .ot_flag(ot_flag), .safe_flag(safe_flag), .oc_flag(oc_flag), .uv_flag(uv_flag),
      .drv_en(drv_en), .pup_busy(pup_busy), .pdn_busy(pdn_busy), .ramp_done(ramp_done),
      .st_therm(st_therm), .st_short(st_short), .st_uv(st_uv)
   );

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // count negedges until drv_en equals val (limit guards a hang)
   task automatic wait_drv(input logic val, input int limit, output int cnt);
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (drv_en !== val && cnt < limit);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; por_hold = 1'b1; en = 1'b1;
      ot_flag = 1'b0; safe_flag = 1'b0; oc_flag = 1'b0; uv_flag = 1'b0;
      tick(3);
      check(drv_en === 1'b0, "R1 drv_en in reset", int'(drv_en), 0);
      rst_n = 1'b1;
      tick(4);
      check(drv_en === 1'b0 && pup_busy === 1'b0 && ramp_done === 1'b0,
            "R1 held by por", int'({drv_en, pup_busy, ramp_done}), 0);
      por_hold = 1'b0; en = 1'b0;
      tick(2);
   endtask

   task automatic t_powerup;
      int cnt;
      en = 1'b1;
      tick(1);
      check(pup_busy === 1'b1, "R2 ramp starts", int'(pup_busy), 1);
      check(drv_en === 1'b0, "R2 no drive in ramp", int'(drv_en), 0);
      cnt = 1;
      while (ramp_done !== 1'b1 && cnt < 300) begin
         @(negedge clk);
         cnt++;
      end
      check(cnt >= UP && cnt <= UP + 2, "R2 ramp length", cnt, UP + 1);
      check(drv_en === 1'b1, "R2 drive after ramp", int'(drv_en), 1);
   endtask

   task automatic t_thermal;
      ot_flag = 1'b1;
      #1;
      check(drv_en === 1'b0, "R4 immediate cut", int'(drv_en), 0);
      tick(1);
      check(st_therm === 1'b1, "R4 sticky set", int'(st_therm), 1);
      ot_flag = 1'b0; safe_flag = 1'b0;
      tick(10);
      check(drv_en === 1'b0, "R5 held without safe", int'(drv_en), 0);
      safe_flag = 1'b1; tick(REC - 5);
      safe_flag = 1'b0; tick(1);
      safe_flag = 1'b1; tick(REC - 3);
      check(drv_en === 1'b0, "R5 break restarts count", int'(drv_en), 0);
      tick(6);
      check(drv_en === 1'b1, "R5 recovered", int'(drv_en), 1);
      check(st_therm === 1'b1, "R4 sticky kept", int'(st_therm), 1);
   endtask

   task automatic t_glitch;
      oc_flag = 1'b1;
      for (int i = 0; i < FILT - 1; i++) begin
         #1;
         check(drv_en === 1'b1, "R6 drive kept in glitch", int'(drv_en), 1);
         @(negedge clk);
      end
      oc_flag = 1'b0;
      tick(3);
      check(drv_en === 1'b1 && st_short === 1'b0, "R6 glitch ignored",
            int'({drv_en, st_short}), 2);
   endtask

   task automatic t_hiccup;
      int c;
      oc_flag = 1'b1;
      wait_drv(1'b0, 200, c);
      check(c >= FILT && c <= FILT + 1, "R7 filter window", c, FILT);
      check(st_short === 1'b1, "R7 sticky set", int'(st_short), 1);
      wait_drv(1'b1, 500, c);
      check(c >= OFFW - 1 && c <= OFFW + 1, "R7 off window", c, OFFW);
      wait_drv(1'b0, 200, c);
      check(c >= FILT - 1 && c <= FILT + 1, "R8 retry on time", c, FILT);
      wait_drv(1'b1, 500, c);
      check(c >= OFFW - 1 && c <= OFFW + 1, "R8 second off window", c, OFFW);
      oc_flag = 1'b0;
      tick(OFFW + 3);
      check(drv_en === 1'b1, "R8 resumes after short removed", int'(drv_en), 1);
   endtask

   task automatic t_uv;
      uv_flag = 1'b1;
      #1;
      check(drv_en === 1'b0, "R9 uv cut", int'(drv_en), 0);
      tick(3);
      check(ramp_done === 1'b1 && st_uv === 1'b1, "R9 sequencing kept",
            int'({ramp_done, st_uv}), 3);
      uv_flag = 1'b0;
      tick(1);
      check(drv_en === 1'b1, "R9 drive returns", int'(drv_en), 1);
   endtask

   task automatic t_powerdown;
      en = 1'b0;
      #1;
      check(drv_en === 1'b0, "R3 en cut", int'(drv_en), 0);
      tick(1);
      check(pdn_busy === 1'b1, "R3 fall ramp", int'(pdn_busy), 1);
      check({st_therm, st_short, st_uv} === 3'b000, "R10 sticky cleared",
            int'({st_therm, st_short, st_uv}), 0);
      tick(2);
      en = 1'b1;
      tick(1);
      check(pdn_busy === 1'b1 && pup_busy === 1'b0, "R3 en ignored mid fall",
            int'({pdn_busy, pup_busy}), 2);
      tick(DOWN + 2);
      check(pdn_busy === 1'b0 && pup_busy === 1'b1, "R3 ramp after fall",
            int'({pdn_busy, pup_busy}), 1);
   endtask

   task automatic t_abort;
      tick(5);
      en = 1'b0;
      tick(1);
      check(pdn_busy === 1'b1 && pup_busy === 1'b0, "R11 ramp aborted",
            int'({pdn_busy, pup_busy}), 2);
      tick(DOWN + 2);
      check({pup_busy, pdn_busy, ramp_done} === 3'b000, "R11 idle after abort",
            int'({pup_busy, pdn_busy, ramp_done}), 0);
   endtask

   task automatic t_fault_clear;
      int c;
      en = 1'b1;
      tick(UP + 3);
      safe_flag = 1'b0;
      ot_flag = 1'b1;
      tick(2);
      en = 1'b0; ot_flag = 1'b0;
      tick(DOWN + 3);
      en = 1'b1;
      wait_drv(1'b1, UP + 10, c);
      check(drv_en === 1'b1, "R3 lockout cleared by en low", int'(drv_en), 1);
      check(st_therm === 1'b0, "R10 sticky stays clear", int'(st_therm), 0);
   endtask

   initial begin
      t_reset();
      t_powerup();
      t_thermal();
      t_glitch();
      t_hiccup();
      t_uv();
      t_powerdown();
      t_abort();
      t_fault_clear();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule